// File: doc/BRIEF.md
# Dual-Source DAC Code Loader

This block holds the 8-bit code that a downstream DAC modulator converts. The code can arrive from either of two sources, chosen by a mode pin. In parallel mode, eight data pins are sampled when a strobe line goes high. In serial mode, a three-wire SPI-style link shifts the code in. The link uses an active-low select, a serial clock and a data line. The parallel strobe and the serial select are one shared pin, and its meaning follows the mode pin.

All control pins are asynchronous to the system clock. The mode, shared strobe/select, serial clock and serial data pins each pass through a two-stage synchronizer, and edges are found in the system clock domain. The parallel data pins must be held steady around the strobe edge, so they are sampled without a synchronizer.

A small state machine tracks each serial frame. Its states are IDLE (no frame open), SHIFT (select low, counting bits), OVERRUN (more clock edges than code bits) and COMMIT (a one-cycle state that hands the finished code to the holding register). Its transitions are:
- IDLE to SHIFT when serial mode is selected and select is low.
- SHIFT to COMMIT when select rises with exactly eight bits counted.
- SHIFT to IDLE when select rises with too few bits, or when the mode leaves serial.
- SHIFT to OVERRUN on a serial clock edge after eight bits.
- OVERRUN to IDLE when select rises or the mode leaves serial.
- COMMIT to IDLE unconditionally.

Top module: `code_loader`

## Requirements
- R1: After reset `code_out` is 0x00 and `code_upd` is low. Reset also empties the serial shift register and the bit counter.
- R2: `mode_sel`=0 selects parallel loading and `mode_sel`=1 selects serial loading. In parallel mode, activity on the serial clock and data pins leaves `code_out` unchanged. In serial mode, a rise of the shared pin never captures `par_data`.
- R3: In parallel mode, a rising edge on `latch_cs_n` loads `par_data` into `code_out`.
- R4: In serial mode, `ser_din` is sampled on each rising edge of `ser_clk` while `latch_cs_n` is low. The first bit sampled ends up as bit 7 of the code, so the code is sent most significant bit first.
- R5: A serial frame updates `code_out` only when `latch_cs_n` rises after exactly 8 sampled bits. Before that rise, `code_out` keeps its old value.
- R6: A frame with fewer than 8 bits, including a frame with no bits at all, leaves `code_out` unchanged.
- R7: A frame with more than 8 bits leaves `code_out` unchanged.
- R8: `code_upd` goes high for exactly one clock on every accepted load, in the same cycle that the new value first appears on `code_out`. This happens even when the value loaded equals the old one. `code_out` never changes while `code_upd` is low.
- R9: If the mode switches to parallel while a frame is open, the frame is discarded. The next rise of the shared pin then loads `par_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_sel | input | 1 | Source select: 0 parallel, 1 serial |
| par_data | input | 8 | Parallel code input |
| latch_cs_n | input | 1 | Parallel strobe (rising edge) or serial select (active low) |
| ser_clk | input | 1 | Serial clock; data sampled on its rising edge |
| ser_din | input | 1 | Serial data, MSB first |
| code_out | output | 8 | Held DAC code |
| code_upd | output | 1 | One-cycle pulse on each accepted load |

## Verification
Some rules are checked by assertions on every cycle. These are: the update pulse lasts a single cycle, the held code never changes without the pulse, the bit counter never goes past the code width, and COMMIT is entered only from SHIFT with a full count and always leads back to IDLE. The bench scenarios are needed for the rest: the MSB-first bit order, the values captured from each source, and that short, long, aborted and wrong-mode activity all leave the code untouched. Each of these depends on a specific stimulus sequence at the pins.

// File: rtl/code_loader_pkg.sv
package code_loader_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_SHIFT   = 2'd1,
        ST_OVERRUN = 2'd2,
        ST_COMMIT  = 2'd3
    } frame_state_e;

    // positions in the synchronizer bank
    localparam int SYN_PIN  = 0;
    localparam int SYN_SCLK = 1;
    localparam int SYN_SDIN = 2;
    localparam int SYN_MODE = 3;
    localparam int SYN_W    = 4;
endpackage

// File: rtl/cl_sync_bank.sv
module cl_sync_bank #(
    parameter int            WIDTH   = 4,
    parameter int            STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                chain <= {STAGES{RST_VAL[b]}};
            end else begin
                chain <= {chain[STAGES-2:0], async_in[b]};
            end
        end
        assign sync_out[b] = chain[STAGES-1];
    end
endmodule

// File: rtl/cl_serial_fsm.sv
module cl_serial_fsm
    import code_loader_pkg::*;
#(
    parameter int CODE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_mode,
    input  logic              cs_n,
    input  logic              sclk_rise,
    input  logic              sdin,
    output logic              frame_load,
    output logic [CODE_W-1:0] frame_code
);
    localparam int CNT_W = $clog2(CODE_W + 1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(CODE_W);

    frame_state_e      state_q, state_d;
    logic [CODE_W-1:0] shreg_q;
    logic [CNT_W-1:0]  cnt_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (spi_mode && !cs_n) state_d = ST_SHIFT;
            end
            ST_SHIFT: begin
                if (!spi_mode)                 state_d = ST_IDLE;
                else if (cs_n)                 state_d = (cnt_q == FULL) ? ST_COMMIT : ST_IDLE;
                else if (sclk_rise && cnt_q == FULL) state_d = ST_OVERRUN;
            end
            ST_OVERRUN: begin
                if (!spi_mode || cs_n) state_d = ST_IDLE;
            end
            ST_COMMIT: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // shift register and bit counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg_q <= '0;
            cnt_q   <= '0;
        end else if (state_q == ST_IDLE && state_d == ST_SHIFT) begin
            cnt_q <= '0;
        end else if (state_q == ST_SHIFT && state_d == ST_SHIFT && sclk_rise && cnt_q != FULL) begin
            shreg_q <= {shreg_q[CODE_W-2:0], sdin};
            cnt_q   <= cnt_q + 1'b1;
        end
    end

    // outputs
    always_comb begin
        frame_load = (state_q == ST_COMMIT);
        frame_code = shreg_q;
    end

    assert_cnt_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= FULL);
    assert_commit_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SHIFT && cs_n && spi_mode && cnt_q != FULL) |=> state_q != ST_COMMIT);
    assert_commit_exit_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_COMMIT) |=> (state_q == ST_IDLE));
    assert_abort_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SHIFT && !spi_mode) |=> state_q == ST_IDLE);
endmodule

// File: rtl/code_loader.sv
module code_loader
    import code_loader_pkg::*;
#(
    parameter int CODE_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_sel,
    input  logic [CODE_W-1:0] par_data,
    input  logic              latch_cs_n,
    input  logic              ser_clk,
    input  logic              ser_din,
    output logic [CODE_W-1:0] code_out,
    output logic              code_upd
);
    localparam logic [SYN_W-1:0] SYN_RST = SYN_W'(1) << SYN_PIN;

    logic [SYN_W-1:0]  raw, syn;
    logic              pin_d, sclk_d;
    logic              pin_rise, sclk_rise, par_load, ser_load;
    logic [CODE_W-1:0] ser_code;
    logic [CODE_W-1:0] code_q;
    logic              upd_q;

    always_comb begin
        raw           = '0;
        raw[SYN_PIN]  = latch_cs_n;
        raw[SYN_SCLK] = ser_clk;
        raw[SYN_SDIN] = ser_din;
        raw[SYN_MODE] = mode_sel;
    end

    cl_sync_bank #(.WIDTH(SYN_W), .STAGES(SYNC_STAGES), .RST_VAL(SYN_RST)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_in(raw), .sync_out(syn)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pin_d  <= 1'b1;
            sclk_d <= 1'b0;
        end else begin
            pin_d  <= syn[SYN_PIN];
            sclk_d <= syn[SYN_SCLK];
        end
    end

    assign pin_rise  = syn[SYN_PIN] & ~pin_d;
    assign sclk_rise = syn[SYN_SCLK] & ~sclk_d;
    assign par_load  = pin_rise & ~syn[SYN_MODE];

    cl_serial_fsm #(.CODE_W(CODE_W)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .spi_mode(syn[SYN_MODE]), .cs_n(syn[SYN_PIN]),
        .sclk_rise(sclk_rise), .sdin(syn[SYN_SDIN]),
        .frame_load(ser_load), .frame_code(ser_code)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code_q <= '0;
            upd_q  <= 1'b0;
        end else begin
            upd_q <= ser_load | par_load;
            if (ser_load)      code_q <= ser_code;
            else if (par_load) code_q <= par_data;
        end
    end

    assign code_out = code_q;
    assign code_upd = upd_q;

    assert_upd_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        code_upd |=> !code_upd);
    assert_change_has_upd_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (code_out != $past(code_out)) |-> code_upd);
endmodule

// File: tb/tb_code_loader.sv
module tb_code_loader;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         mode_sel = 1'b0;
    logic [W-1:0] par_data = '0;
    logic         latch_cs_n = 1'b1;
    logic         ser_clk = 1'b0;
    logic         ser_din = 1'b0;
    logic [W-1:0] code_out;
    logic         code_upd;

    int total = 0;
    int bad = 0;
    int upd_cnt = 0;
    bit done = 0;

    code_loader #(.CODE_W(W)) dut (
        .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .par_data(par_data),
        .latch_cs_n(latch_cs_n), .ser_clk(ser_clk), .ser_din(ser_din),
        .code_out(code_out), .code_upd(code_upd)
    );

    always #4 clk = ~clk;

    always @(negedge clk) if (rst_n && code_upd) upd_cnt++;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic par_strobe(input logic [W-1:0] val);
        latch_cs_n = 1'b0; idle(6);
        par_data = val;    idle(2);
        latch_cs_n = 1'b1; idle(8);
    endtask

    task automatic spi_bits(input int n, input logic [15:0] bits);
        for (int i = n - 1; i >= 0; i--) begin
            ser_din = bits[i]; idle(4);
            ser_clk = 1'b1;    idle(4);
            ser_clk = 1'b0;    idle(4);
        end
    endtask

    task automatic spi_frame(input int n, input logic [15:0] bits);
        latch_cs_n = 1'b0; idle(6);
        spi_bits(n, bits);
        latch_cs_n = 1'b1; idle(10);
    endtask

    task automatic t_reset;
        chk(code_out == 8'h00, "R1 reset code", code_out, 0);
        chk(code_upd == 1'b0, "R1 reset pulse", code_upd, 0);
    endtask

    task automatic t_parallel;
        int c0 = upd_cnt;
        par_strobe(8'hA5);
        chk(code_out == 8'hA5, "R3 parallel A5", code_out, 8'hA5);
        par_strobe(8'h3C);
        chk(code_out == 8'h3C, "R3 parallel 3C", code_out, 8'h3C);
        chk(upd_cnt - c0 == 2, "R8 pulse per load", upd_cnt - c0, 2);
        par_strobe(8'h3C);
        chk(upd_cnt - c0 == 3, "R8 pulse on equal value", upd_cnt - c0, 3);
    endtask

    task automatic t_serial_in_par_mode;
        int c0 = upd_cnt;
        par_data = 8'h3C;
        spi_bits(8, 16'h00FF);
        idle(10);
        chk(code_out == 8'h3C && upd_cnt == c0, "R2 serial ignored in parallel", code_out, 8'h3C);
    endtask

    task automatic t_serial;
        mode_sel = 1'b1; idle(8);
        par_data = 8'h77;
        spi_frame(8, 16'h0096);
        chk(code_out == 8'h96, "R4 serial 96", code_out, 8'h96);
        spi_frame(8, 16'h0001);
        chk(code_out == 8'h01, "R4 msb first", code_out, 8'h01);
    endtask

    task automatic t_commit_on_rise;
        int c0 = upd_cnt;
        latch_cs_n = 1'b0; idle(6);
        spi_bits(8, 16'h005A);
        idle(10);
        chk(code_out == 8'h01, "R5 held before select rise", code_out, 8'h01);
        latch_cs_n = 1'b1; idle(10);
        chk(code_out == 8'h5A, "R5 loaded after select rise", code_out, 8'h5A);
        chk(upd_cnt - c0 == 1, "R8 serial pulse", upd_cnt - c0, 1);
    endtask

    task automatic t_bad_frames;
        int c0 = upd_cnt;
        spi_frame(5, 16'h001F);
        chk(code_out == 8'h5A, "R6 short frame", code_out, 8'h5A);
        spi_frame(0, 16'h0000);
        chk(code_out == 8'h5A, "R6 empty frame / R2 no parallel capture", code_out, 8'h5A);
        spi_frame(9, 16'h01C3);
        chk(code_out == 8'h5A, "R7 long frame", code_out, 8'h5A);
        chk(upd_cnt == c0, "R6 R7 no pulse", upd_cnt - c0, 0);
    endtask

    task automatic t_abort;
        latch_cs_n = 1'b0; idle(6);
        spi_bits(8, 16'h00E1);
        par_data = 8'h42;
        mode_sel = 1'b0; idle(8);
        latch_cs_n = 1'b1; idle(10);
        chk(code_out == 8'h42, "R9 abort then parallel", code_out, 8'h42);
    endtask

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(6);
        t_reset;
        t_parallel;
        t_serial_in_par_mode;
        t_serial;
        t_commit_on_rise;
        t_bad_frames;
        t_abort;
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                total++; bad++;
                $display("FAIL watchdog actual=0 expected=1");
            end
        join_any
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule